// File: doc/BRIEF.md
# Threshold-Neuron Parity Evaluator

This block computes the even/odd parity of an N-bit word with a two-layer network of hard-threshold neurons instead of a tree of exclusive-OR gates. Each input bit enters the first layer as a signed level. Every first-layer neuron gives each input the same weight of one, so every neuron sees the same population count. The neurons differ only in their bias, which makes each one a count comparator with its own threshold. The first-layer decisions together form a thermometer code of the number of set bits.

A single output neuron then adds those decisions with weights of alternating sign plus a small bias. The sign of that sum is the parity. All arithmetic uses small signed integers.

A parameter selects between two arithmetic forms. In the signed-level form, bits count as +1 or -1. In the doubled 0/1 form, bits count as 2 or 0 and the biases are rescaled, so no half values appear. Both forms give identical decisions. A second parameter adds an output register stage. That stage captures a result only when the input is flagged valid and delays the valid flag to match. The first-layer decision vector is brought out next to the parity bit so it can be observed.

Top module: `thresh_parity_net`

## Requirements
- R1: `parity_o` equals the exclusive-OR of all bits of the most recently captured `data_i`: 1 when an odd number of bits were set, 0 when an even number were set.
- R2: `hidden_o[b]` is 1 exactly when the captured word has at least N-b set bits. Bit b is the decision of first-layer neuron b+1. So `hidden_o[0]` is set only when every bit is set, and `hidden_o[N-1]` is set when any bit is set.
- R3: `hidden_o` depends only on how many bits are set, not on their positions. Two words with equal population count give identical `hidden_o`.
- R4: `hidden_o` is always a thermometer code that is filled from bit N-1 downward. If bit b is set, every bit above b is also set.
- R5: With the register stage present, a word applied with `in_valid` high in one cycle appears on `parity_o` and `hidden_o` after the next rising clock edge. `valid_o` is `in_valid` delayed by exactly one clock.
- R6: While `in_valid` is low, `parity_o` and `hidden_o` keep their previous values, whatever `data_i` does.
- R7: A synchronous active-high `rst` clears `valid_o`, `parity_o` and `hidden_o` to 0. It takes priority over a capture requested in the same cycle.
- R8: The signed-level form (UNIPOLAR=0) and the doubled 0/1 form (UNIPOLAR=1) produce the same `parity_o` and `hidden_o` for every input word.
- R9: An all-zero word gives `hidden_o` = 0 and `parity_o` = 0. An all-ones word gives `hidden_o` all ones and `parity_o` = N mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `data_i` as a word to evaluate and capture |
| data_i | input | N | Word whose parity is computed |
| valid_o | output | 1 | `in_valid` delayed to line up with the results |
| parity_o | output | 1 | Parity decision of the output neuron |
| hidden_o | output | N | First-layer neuron decisions, bit b = neuron b+1 |

## Verification
Reset and capture can both act on the register stage in the same clock. The bench provokes this by driving a word with odd parity and a non-empty count while `in_valid` and `rst` are both high. After that edge it expects `valid_o`, `parity_o` and `hidden_o` to read all zero, then confirms that the next ordinary capture behaves normally. Capture and hold are also placed back to back, and the bench checks that a word changed under a low `in_valid` leaves the previous results in place.

// File: rtl/thr_parity_pkg.sv
package thr_parity_pkg;

    // Output stage state carried alongside the first-layer vector
    typedef struct packed {
        logic valid;
        logic parity;
    } tpn_stat_t;

    // Width of a signed net sum able to hold +/-(2n+1)
    function automatic int net_width(int n);
        return $clog2(2 * n + 2) + 2;
    endfunction

    // Bias of first-layer neuron k (1-based) so that it fires when count >= n+1-k.
    // Doubled 0/1 form: 2k-2n-1, signed-level form: 2k-n-1.
    function automatic int hid_bias(int k, int n, bit uni);
        return uni ? (2 * k - 2 * n - 1) : (2 * k - n - 1);
    endfunction

    // Output-neuron weight for first-layer neuron k (1-based): the first is
    // +1 for odd n and -1 for even n, the rest alternate in sign.
    function automatic int out_weight(int k, int n);
        int w1;
        w1 = 2 * (n % 2) - 1;
        return (k % 2 == 1) ? w1 : -w1;
    endfunction

    // Output-neuron bias: (n mod 2)-1 in signed-level form, -1 in doubled form
    function automatic int out_bias(int n, bit uni);
        return uni ? -1 : ((n % 2) - 1);
    endfunction

endpackage

// File: rtl/tpn_input_sum.sv
module tpn_input_sum
    import thr_parity_pkg::*;
#(
    parameter int N        = 16,
    parameter bit UNIPOLAR = 1'b0,
    localparam int SW      = net_width(N)
) (
    input  logic [N-1:0]          data_i,
    output logic signed [SW-1:0]  sum_o
);
    // Level of a set bit and of a clear bit in the chosen arithmetic form
    localparam logic signed [SW-1:0] LVL_HI = UNIPOLAR ? SW'(2) : SW'(1);
    localparam logic signed [SW-1:0] LVL_LO = UNIPOLAR ? SW'(0) : SW'(-1);

    always_comb begin
        sum_o = '0;
        for (int b = 0; b < N; b++) begin
            sum_o = sum_o + (data_i[b] ? LVL_HI : LVL_LO);
        end
    end
endmodule

// File: rtl/tpn_hidden_layer.sv
module tpn_hidden_layer
    import thr_parity_pkg::*;
#(
    parameter int N        = 16,
    parameter bit UNIPOLAR = 1'b0,
    localparam int SW      = net_width(N)
) (
    input  logic signed [SW-1:0]  sum_i,
    output logic [N-1:0]          fire_o
);
    localparam logic signed [SW-1:0] ZERO = '0;

    for (genvar k = 0; k < N; k++) begin : g_neuron
        localparam logic signed [SW-1:0] BIAS = SW'(hid_bias(k + 1, N, UNIPOLAR));
        logic signed [SW-1:0] net;
        assign net       = sum_i + BIAS;
        assign fire_o[k] = (net > ZERO);
    end
endmodule

// File: rtl/tpn_output_neuron.sv
module tpn_output_neuron
    import thr_parity_pkg::*;
#(
    parameter int N        = 16,
    parameter bit UNIPOLAR = 1'b0,
    localparam int SW      = net_width(N)
) (
    input  logic [N-1:0] hid_i,
    output logic         fire_o
);
    localparam logic signed [SW-1:0] ZERO = '0;
    localparam logic signed [SW-1:0] BIAS = SW'(out_bias(N, UNIPOLAR));

    logic signed [SW-1:0] term [N];
    logic signed [SW-1:0] net;

    for (genvar k = 0; k < N; k++) begin : g_term
        localparam int WT = out_weight(k + 1, N);
        localparam logic signed [SW-1:0] T_ON  = UNIPOLAR ? SW'(2 * WT) : SW'(WT);
        localparam logic signed [SW-1:0] T_OFF = UNIPOLAR ? SW'(0)      : SW'(-WT);
        assign term[k] = hid_i[k] ? T_ON : T_OFF;
    end

    always_comb begin
        net = BIAS;
        for (int k = 0; k < N; k++) begin
            net = net + term[k];
        end
    end

    assign fire_o = (net > ZERO);
endmodule

// File: rtl/thresh_parity_net.sv
module thresh_parity_net
    import thr_parity_pkg::*;
#(
    parameter int N          = 16,
    parameter bit UNIPOLAR   = 1'b0,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] data_i,
    output logic         valid_o,
    output logic         parity_o,
    output logic [N-1:0] hidden_o
);
    localparam int SW = net_width(N);

    logic signed [SW-1:0] in_sum;
    logic [N-1:0]         hid_comb;
    logic                 par_comb;

    tpn_input_sum #(.N(N), .UNIPOLAR(UNIPOLAR)) u_sum (
        .data_i (data_i),
        .sum_o  (in_sum)
    );

    tpn_hidden_layer #(.N(N), .UNIPOLAR(UNIPOLAR)) u_hid (
        .sum_i  (in_sum),
        .fire_o (hid_comb)
    );

    tpn_output_neuron #(.N(N), .UNIPOLAR(UNIPOLAR)) u_out (
        .hid_i  (hid_comb),
        .fire_o (par_comb)
    );

    if (REGISTERED) begin : g_reg
        tpn_stat_t    stat_q;
        logic [N-1:0] hid_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q <= '0;
                hid_q  <= '0;
            end else begin
                stat_q.valid <= in_valid;
                if (in_valid) begin
                    stat_q.parity <= par_comb;
                    hid_q         <= hid_comb;
                end
            end
        end

        assign valid_o  = stat_q.valid;
        assign parity_o = stat_q.parity;
        assign hidden_o = hid_q;
    end else begin : g_comb
        tpn_stat_t stat_c;
        assign stat_c   = '{valid: in_valid, parity: par_comb};
        assign valid_o  = stat_c.valid;
        assign parity_o = stat_c.parity;
        assign hidden_o = hid_comb;
    end
endmodule

// File: rtl/tpn_checker.sv
module tpn_checker #(
    parameter int N          = 16,
    parameter bit REGISTERED = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [N-1:0] data_i,
    input logic         valid_o,
    input logic         parity_o,
    input logic [N-1:0] hidden_o
);
    logic [N-1:0] inv_hid;
    assign inv_hid = ~hidden_o;

    // R4: cleared bits of the first-layer vector sit contiguously at the bottom
    p_thermo_r4: assert property (@(posedge clk) disable iff (rst)
        (inv_hid & (inv_hid + 1'b1)) == '0);

    // R1: the output neuron agrees with the parity of the first-layer count
    p_par_vs_hidden_r1: assert property (@(posedge clk) disable iff (rst)
        parity_o == ^hidden_o);

    if (REGISTERED) begin : g_seq
        p_parity_r1: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> parity_o == ^$past(data_i));

        p_count_r2: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> $countones(hidden_o) == $countones($past(data_i)));

        p_valid_hi_r5: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> valid_o);

        p_valid_lo_r5: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !valid_o);

        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(parity_o) && $stable(hidden_o)));
    end
endmodule

bind thresh_parity_net tpn_checker #(.N(N), .REGISTERED(REGISTERED)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .data_i   (data_i),
    .valid_o  (valid_o),
    .parity_o (parity_o),
    .hidden_o (hidden_o)
);

// File: tb/thresh_parity_net_test.sv
module thresh_parity_net_test;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] data_i = '0;
    logic         valid_o, parity_o, valid_u, parity_u;
    logic [N-1:0] hidden_o, hidden_u;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    thresh_parity_net #(.N(N), .UNIPOLAR(1'b0), .REGISTERED(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .data_i(data_i),
        .valid_o(valid_o), .parity_o(parity_o), .hidden_o(hidden_o));

    thresh_parity_net #(.N(N), .UNIPOLAR(1'b1), .REGISTERED(1'b1)) uut_uni (
        .clk(clk), .rst(rst), .in_valid(in_valid), .data_i(data_i),
        .valid_o(valid_u), .parity_o(parity_u), .hidden_o(hidden_u));

    function automatic logic [N-1:0] exp_hidden(int cnt);
        logic [N-1:0] r;
        for (int b = 0; b < N; b++) r[b] = (cnt >= N - b);
        return r;
    endfunction

    function automatic int popc(logic [N-1:0] v);
        int c = 0;
        for (int b = 0; b < N; b++) c += int'(v[b]);
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one word for one clock; return at the following falling edge
    task automatic apply(logic [N-1:0] v);
        @(negedge clk);
        data_i   = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_word(string req, logic [N-1:0] v);
        check({req, " parity"}, 32'(parity_o), 32'(^v));
        check({req, " hidden"}, 32'(hidden_o), 32'(exp_hidden(popc(v))));
        check({req, " R8 parity"}, 32'(parity_u), 32'(parity_o));
        check({req, " R8 hidden"}, 32'(hidden_u), 32'(hidden_o));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 valid", 32'(valid_o), 32'd0);
        check("R7 parity", 32'(parity_o), 32'd0);
        check("R7 hidden", 32'(hidden_o), 32'd0);
    endtask

    task automatic t_leading_ones();
        apply('0);
        check_word("R9 zeros", '0);
        for (int c = 1; c <= N; c++) begin
            logic [N-1:0] v;
            v = '0;
            for (int b = 0; b < c; b++) v[N-1-b] = 1'b1;
            apply(v);
            check_word("R1/R2 leading", v);
        end
        check("R9 ones parity", 32'(parity_o), 32'(N % 2));
        check("R9 ones hidden", 32'(hidden_o), 32'({N{1'b1}}));
    endtask

    task automatic t_placement();
        logic [N-1:0] first;
        apply(16'h000F);
        first = hidden_o;
        apply(16'h8421);
        check("R3 same count", 32'(hidden_o), 32'(first));
        apply(16'hA000 | 16'h0003);
        check("R3 same count", 32'(hidden_o), 32'(first));
        check_word("R2 placement", 16'hA003);
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            logic [N-1:0] v;
            v = N'($urandom);
            apply(v);
            check_word("R1 random", v);
        end
    endtask

    task automatic t_latency();
        apply(16'h0003);
        @(negedge clk);
        data_i   = 16'h0007;
        in_valid = 1'b1;
        #1;
        check("R5 before edge", 32'(parity_o), 32'd0);
        check("R5 valid before", 32'(valid_o), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 after edge", 32'(parity_o), 32'd1);
        check("R5 valid after", 32'(valid_o), 32'd1);
        @(negedge clk);
        check("R5 valid drop", 32'(valid_o), 32'd0);
    endtask

    task automatic t_hold();
        apply(16'h0107);
        @(negedge clk);
        data_i = 16'hFFFE;
        @(negedge clk);
        data_i = 16'h0001;
        @(negedge clk);
        check("R6 hold parity", 32'(parity_o), 32'(^16'h0107));
        check("R6 hold hidden", 32'(hidden_o), 32'(exp_hidden(4)));
        check("R6 valid low", 32'(valid_o), 32'd0);
    endtask

    task automatic t_reset_vs_capture();
        apply(16'h00FF);
        @(negedge clk);
        data_i   = 16'h0111;
        in_valid = 1'b1;
        rst      = 1'b1;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        check("R7 priority valid", 32'(valid_o), 32'd0);
        check("R7 priority parity", 32'(parity_o), 32'd0);
        check("R7 priority hidden", 32'(hidden_o), 32'd0);
        apply(16'h0111);
        check_word("R7 recover", 16'h0111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_leading_ones();
        t_placement();
        t_random();
        t_latency();
        t_hold();
        t_reset_vs_capture();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule